// File: doc/BRIEF.md
# Back-Pressured Word Stream Source

This block buffers words written by an upstream producer and hands them to a downstream consumer as a registered valid/data stream, one word per clock. The consumer controls the flow with a single level-sensitive throttle input, `xoff`. While `xoff` is high the source goes quiet. When `xoff` drops, the source picks up again at once with the next pending word.

The throttle has tight timing. The stream may carry a word in the cycle in which `xoff` is first sampled high, but never after that. The word shown in that cycle counts as delivered and is not sent again. Words always leave in write order, and throttling only delays them. The upstream side sees a `full` flag, and any write made while `full` is high is discarded and latches a sticky `overflow` flag. The buffer depth, the word width and the value driven on `out_data` when the stream is idle are all parameters.

Top module: `xoff_stream_tx`

## Requirements
- R1: A synchronous active-high reset empties the buffer. After the reset edge, `out_valid`, `full` and `overflow` are all low.
- R2: If `xoff` is high at a rising edge, `out_valid` is low after that edge. A word can therefore appear in the first cycle in which `xoff` is high, but in no later cycle.
- R3: As long as `xoff` stays high for consecutive edges, `out_valid` stays low in every cycle after the first, without exception.
- R4: If `xoff` is low at an edge and at least one word is buffered, `out_valid` is high after that edge. This meets the two-clock resume bound with one clock to spare.
- R5: If the buffer is empty at an edge, `out_valid` is low after that edge, whatever the level of `xoff`.
- R6: Each cycle with `out_valid` high delivers exactly one word and removes it from the buffer. A word shown in the cycle in which `xoff` rises is not repeated.
- R7: Words appear on `out_data` in the order in which they were accepted. None is lost or duplicated by throttling.
- R8: `full` is high exactly when DEPTH words are held. A write at an edge where `full` is high is discarded, even if a word leaves at the same edge.
- R9: A discarded write sets `overflow`, and `overflow` stays high until reset.
- R10: A word written into an empty buffer while `xoff` stays low appears on the output after the next rising edge, two edges after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the producer |
| wr_data | input | WIDTH | Word to be buffered |
| full | output | 1 | Buffer holds DEPTH words |
| overflow | output | 1 | Sticky flag: a write was discarded |
| xoff | input | 1 | Throttle from the consumer, already synchronous |
| out_valid | output | 1 | Registered word-present strobe |
| out_data | output | WIDTH | Registered word |

## Verification
The bench builds the block with DEPTH = 3 and WIDTH = 8. A depth that is not a power of two selects the explicit pointer-wrap variant, and a three-entry buffer fills and overflows within a few cycles, even while the throttle is active. The bench sweeps throttle periods of one to four cycles against write spacings of one to four cycles, then runs a pseudo-random stretch. These runs bring in every phase between an `xoff` edge and a buffer that is empty, one word from empty or full. The bench predicts the state of the block cycle by cycle from the requirements and compares the outputs in every cycle.

// File: rtl/xt_pkg.sv
package xt_pkg;

   // Value driven on out_data while no word is presented
   typedef enum logic {
      XT_IDLE_HOLD = 1'b0,
      XT_IDLE_ZERO = 1'b1
   } xt_idle_e;

   function automatic int unsigned xt_cnt_w(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   function automatic int unsigned xt_ptr_w(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   function automatic bit xt_is_pow2(input int unsigned depth);
      return (depth != 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/xt_fifo.sv
module xt_fifo
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_req,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic             overflow
);
   localparam int unsigned AW = xt_ptr_w(DEPTH);
   localparam int unsigned CW = xt_cnt_w(DEPTH);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [CW-1:0]    count;
   logic             push;

   initial begin : elab_chk
      if (DEPTH < 2)  $fatal(1, "xt_fifo: DEPTH must be at least 2");
      if (WIDTH < 1)  $fatal(1, "xt_fifo: WIDTH must be at least 1");
   end

   assign full  = (count == CNT_FULL);
   assign empty = (count == '0);
   assign push  = push_req && !full;
   assign head  = mem[rd_ptr];

   generate
      if (xt_is_pow2(DEPTH)) begin : g_wrap_free
         assign wr_ptr_nx = wr_ptr + 1'b1;
         assign rd_ptr_nx = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr_nx;
         if (pop)  rd_ptr <= rd_ptr_nx;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push_req && full) overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/xt_outstage.sv
module xt_outstage
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter xt_idle_e    IDLE  = XT_IDLE_HOLD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             xoff,
   input  logic             src_empty,
   input  logic [WIDTH-1:0] src_head,
   output logic             pop,
   output logic             valid_q,
   output logic [WIDTH-1:0] data_q
);
   // A word leaves whenever the throttle is low and one is waiting
   assign pop = !xoff && !src_empty;

   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= pop;
   end

   generate
      if (IDLE == XT_IDLE_ZERO) begin : g_idle_zero
         always_ff @(posedge clk) begin
            if (rst)      data_q <= '0;
            else if (pop) data_q <= src_head;
            else          data_q <= '0;
         end
      end else begin : g_idle_hold
         always_ff @(posedge clk) begin
            if (rst)      data_q <= '0;
            else if (pop) data_q <= src_head;
         end
      end
   endgenerate

endmodule

// File: rtl/xoff_stream_tx.sv
module xoff_stream_tx
   import xt_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8,
   parameter xt_idle_e    IDLE  = XT_IDLE_HOLD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             full,
   output logic             overflow,
   input  logic             xoff,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   logic             buf_empty;
   logic             buf_pop;
   logic [WIDTH-1:0] buf_head;

   xt_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push_req  (wr_en),
      .push_data (wr_data),
      .pop       (buf_pop),
      .head      (buf_head),
      .empty     (buf_empty),
      .full      (full),
      .overflow  (overflow)
   );

   xt_outstage #(.WIDTH(WIDTH), .IDLE(IDLE)) u_out (
      .clk       (clk),
      .rst       (rst),
      .xoff      (xoff),
      .src_empty (buf_empty),
      .src_head  (buf_head),
      .pop       (buf_pop),
      .valid_q   (out_valid),
      .data_q    (out_data)
   );

endmodule

// File: rtl/xoff_stream_tx_chk.sv
module xoff_stream_tx_chk (
   input logic clk,
   input logic rst,
   input logic wr_en,
   input logic xoff,
   input logic buf_empty,
   input logic full,
   input logic overflow,
   input logic out_valid
);
   // R1: reset leaves every flag low
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && !full && !overflow));

   // R2: throttle seen high at an edge silences the next cycle
   p_grace_r2: assert property (@(posedge clk) disable iff (rst)
      $past(xoff) |-> !out_valid);

   // R3: sustained throttle keeps the stream silent
   p_pause_r3: assert property (@(posedge clk) disable iff (rst)
      (xoff && $past(xoff)) |-> !out_valid);

   // R4: pending word with throttle low resumes at once
   p_resume_r4: assert property (@(posedge clk) disable iff (rst)
      $past(!xoff && !buf_empty) |-> out_valid);

   // R5: nothing buffered, nothing shown
   p_idle_r5: assert property (@(posedge clk) disable iff (rst)
      $past(buf_empty) |-> !out_valid);

   // R8: a full buffer is never empty
   p_full_r8: assert property (@(posedge clk) disable iff (rst)
      full |-> !buf_empty);

   // R9: discarded write raises the flag, which then stays
   p_drop_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full) |=> overflow);
   p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

endmodule

bind xoff_stream_tx xoff_stream_tx_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .xoff      (xoff),
   .buf_empty (buf_empty),
   .full      (full),
   .overflow  (overflow),
   .out_valid (out_valid)
);

// File: tb/sim_xoff_stream_tx.sv
`timescale 1ns/1ps
module sim_xoff_stream_tx;
   localparam int unsigned W = 8;
   localparam int unsigned D = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         xoff = 1'b0;
   logic         full, overflow, out_valid;
   logic [W-1:0] out_data;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xoff_stream_tx #(.WIDTH(W), .DEPTH(D)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .full(full), .overflow(overflow), .xoff(xoff),
      .out_valid(out_valid), .out_data(out_data)
   );

   // Reference state predicted from the requirements
   logic [W-1:0] mq[$];
   bit           ev, efull, eovf, m_rst, m_prev_xoff, m_was_empty;
   logic [W-1:0] ed;

   always @(posedge clk) begin
      if (rst) begin
         mq.delete();
         ev = 0; eovf = 0; m_rst = 1;
         m_prev_xoff = xoff; m_was_empty = 1;
      end else begin
         int n;
         bit pop;
         n = mq.size();
         m_rst = 0;
         m_prev_xoff = xoff;
         m_was_empty = (n == 0);
         pop = !xoff && (n > 0);
         if (pop) ed = mq.pop_front();
         ev = pop;
         if (wr_en) begin
            if (n == D) eovf = 1;
            else        mq.push_back(wr_data);
         end
      end
      efull = (mq.size() == D);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         string vt;
         if (m_rst)            vt = "R1 valid";
         else if (m_prev_xoff) vt = "R2 R3 valid";
         else if (m_was_empty) vt = "R5 valid";
         else                  vt = "R4 R6 valid";
         check(out_valid == ev, vt, out_valid, ev);
         if (ev) check(out_data == ed, "R7 R10 data order", out_data, ed);
         check(full == efull, m_rst ? "R1 full" : "R8 full", full, efull);
         check(overflow == eovf, m_rst ? "R1 overflow" : "R9 overflow", overflow, eovf);
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic drive(input bit w, input bit x);
      @(negedge clk);
      wr_en = w;
      xoff  = x;
      if (w) wr_data = wr_data + 8'd1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin : stim
      // R1: reset state
      repeat (3) drive(0, 0);
      @(negedge clk) rst = 1'b0;
      // R10 R7: burst with throttle low
      repeat (5) drive(1, 0);
      repeat (6) drive(0, 0);
      // R8 R9: fill behind a pause, drop extra writes
      repeat (6) drive(1, 1);
      repeat (4) drive(0, 1);
      // R2 R3 R4: release, then a single-cycle pause mid-drain
      drive(0, 0);
      drive(0, 1);
      repeat (5) drive(0, 0);
      // write while full while popping: still dropped (R8)
      repeat (3) drive(1, 1);
      drive(1, 0);
      repeat (5) drive(0, 0);
      // R1: reset clears overflow
      drive(0, 0); rst = 1'b1;
      drive(0, 0);
      @(negedge clk) rst = 1'b0;
      // sweep of throttle period against write spacing
      for (int p = 1; p <= 4; p++) begin
         for (int k = 0; k <= 3; k++) begin
            for (int c = 0; c < 48; c++)
               drive((c % (k + 1)) == 0, ((c / p) % 2) == 1);
            repeat (6) drive(0, 0);
         end
      end
      // pseudo-random stretch
      for (int c = 0; c < 1500; c++) begin
         int r;
         r = $urandom_range(0, 7);
         drive(r[0], r[2:1] == 2'b11);
      end
      repeat (6) drive(0, 0);
      drive(0, 0); rst = 1'b1;
      drive(0, 0);
      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule